// File: doc/BRIEF.md
# Multichannel Reference Comparison Fault Detector

This block watches a bank of sampled pins from a device under test and compares each one with the same-numbered pin of a known-good reference device. Every pin has its own comparison lane. A direction flag per pin decides whether the lane compares at all. Pins flagged as outputs are compared with the reference. Pins flagged as inputs are compared with themselves, so they never fail. A discrepancy counts as a pin fault only if it lasts longer than a programmable mask time, given in clock cycles. That time restarts whenever either signal on the pin changes. Per-pin disable bits and a gate-enable input can suppress a pin fault.

A state machine with three states handles capture. `CAP_IDLE` is the armed state: the monitor bus shows the live device pins. The first qualified pin fault takes the transition *arm-to-window* into `CAP_WINDOW`. In that state, further pin faults are ORed into the captured set for a fixed number of cycles. The transition *window-to-frozen* then moves to `CAP_FROZEN`, where the captured set is held for readback. The *clear* transition returns from either capturing state to `CAP_IDLE`. While a fault is captured, the block raises a stop-test request. A CPU force-fault input is ORed into the master fault flag.

Top module: `refcmp_fault_det`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, stop_req and master_fault are 0 (with force_fault low) and mon_bus equals dut_pin. Reset also discards a fault that was already captured.
- R2: A pin whose pin_is_out bit is 0 never produces a fault, however long dut_pin and ref_pin differ on it.
- R3: A pin whose pin_is_out bit is 1 qualifies on the clock edge where dut_pin differs from ref_pin for the (mask_cycles+1)-th edge in a row. A mismatch lasting only mask_cycles edges does not qualify. With mask_cycles = 0, the first mismatched edge qualifies.
- R4: A change of the pin's dut_pin or ref_pin bit restarts the count from one, even if the mismatch persists.
- R5: A pin whose pin_disable bit is 1 never enters the captured set.
- R6: While gate_en is 0, no pin fault is captured. An uninterrupted mismatch qualifies on the first gated edge once its count exceeds the mask.
- R7: The first qualified fault is captured on that edge (arm-to-window). Faults qualifying on the next WIN_CYC edges are ORed in. After that the set is frozen, and later faults are not added.
- R8: In CAP_IDLE, mon_bus is the live dut_pin. In any other state, it is the captured fault set, with bit i meaning pin i.
- R9: stop_req is 1 from the capture edge until the edge on which fault_clear is 1. That edge returns the block to CAP_IDLE with an empty set, and fault_clear takes priority over a new capture.
- R10: master_fault is 1 exactly when force_fault is 1 or a fault is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dut_pin | input | NUM_CH | Sampled device-under-test pins |
| ref_pin | input | NUM_CH | Sampled reference device pins |
| pin_is_out | input | NUM_CH | 1 marks a pin as a device output (compared) |
| pin_disable | input | NUM_CH | 1 suppresses faults on a pin |
| mask_cycles | input | MASK_W | Mismatch length that must be exceeded |
| gate_en | input | 1 | Comparison qualifier; 0 ignores pin faults |
| force_fault | input | 1 | CPU-driven fault injection into master_fault |
| fault_clear | input | 1 | CPU clear of the captured fault |
| mon_bus | output | NUM_CH | Live pins when armed, captured faults otherwise |
| master_fault | output | 1 | Captured fault OR forced fault |
| stop_req | output | 1 | Request to stop the test |

## Verification
The bench builds the block with all 28 channels, a 4-bit mask and a 2-cycle capture window. With a window that short, a test can reach the boundary in a few steps: one pin that joins the window and another that qualifies just after the freeze. A mask of 3 puts the exact-length boundary, the restart on a transition and the gate-release case within a handful of cycles each. Mask 0 covers immediate qualification.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_WINDOW = 2'd1,
        CAP_FROZEN = 2'd2
    } cap_state_e;

endpackage

// File: rtl/refcmp_lane.sv
module refcmp_lane #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dut_bit,
    input  logic              ref_bit,
    input  logic              is_out,
    input  logic [MASK_W-1:0] mask_cycles,
    output logic              over_mask
);
    localparam int CW = MASK_W + 1;
    localparam logic [CW-1:0] CMAX = {1'b1, {MASK_W{1'b0}}};

    logic          dut_q;
    logic          ref_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] run_d;
    logic          mism;
    logic          toggled;

    assign mism    = is_out & (dut_bit ^ ref_bit);
    assign toggled = (dut_bit != dut_q) | (ref_bit != ref_q);

    // run_d is the length of the current mismatch streak, including this edge
    always_comb begin
        if (!mism) begin
            run_d = '0;
        end else if (toggled) begin
            run_d = CW'(1);
        end else if (run_q == CMAX) begin
            run_d = CMAX;
        end else begin
            run_d = run_q + 1'b1;
        end
    end

    assign over_mask = run_d > {1'b0, mask_cycles};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dut_q <= 1'b0;
            ref_q <= 1'b0;
            run_q <= '0;
        end else begin
            dut_q <= dut_bit;
            ref_q <= ref_bit;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/refcmp_qualify.sv
module refcmp_qualify #(
    parameter int NUM_CH = 28
) (
    input  logic [NUM_CH-1:0] over_mask,
    input  logic [NUM_CH-1:0] pin_disable,
    input  logic              gate_en,
    output logic [NUM_CH-1:0] pin_fault
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_qual
        assign pin_fault[g] = over_mask[g] & ~pin_disable[g] & gate_en;
    end
endmodule

// File: rtl/refcmp_capture.sv
module refcmp_capture
    import refcmp_pkg::*;
#(
    parameter int NUM_CH  = 28,
    parameter int WIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_fault,
    input  logic [NUM_CH-1:0] live_bus,
    input  logic              fault_clear,
    output logic [NUM_CH-1:0] mon_bus,
    output logic              holding
);
    localparam int WCW   = (WIN_CYC > 0) ? $clog2(WIN_CYC + 1) : 1;
    localparam int WLAST = (WIN_CYC > 0) ? WIN_CYC - 1 : 0;

    cap_state_e        state_q, state_d;
    logic [NUM_CH-1:0] cap_q, cap_d;
    logic [WCW-1:0]    win_q, win_d;
    logic              any_fault;

    assign any_fault = |pin_fault;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            cap_q   <= '0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            cap_q   <= cap_d;
            win_q   <= win_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cap_d   = cap_q;
        win_d   = win_q;
        if (fault_clear) begin
            state_d = CAP_IDLE;
            cap_d   = '0;
            win_d   = '0;
        end else begin
            unique case (state_q)
                CAP_IDLE: begin
                    if (any_fault) begin
                        cap_d   = pin_fault;
                        win_d   = '0;
                        state_d = (WIN_CYC == 0) ? CAP_FROZEN : CAP_WINDOW;
                    end
                end
                CAP_WINDOW: begin
                    cap_d = cap_q | pin_fault;
                    win_d = win_q + 1'b1;
                    if (win_q == WCW'(WLAST)) begin
                        state_d = CAP_FROZEN;
                    end
                end
                CAP_FROZEN: begin
                    state_d = CAP_FROZEN;
                end
                default: begin
                    state_d = CAP_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        holding = (state_q != CAP_IDLE);
        mon_bus = holding ? cap_q : live_bus;
    end
endmodule

// File: rtl/refcmp_fault_det.sv
module refcmp_fault_det #(
    parameter int NUM_CH  = 28,
    parameter int MASK_W  = 8,
    parameter int WIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dut_pin,
    input  logic [NUM_CH-1:0] ref_pin,
    input  logic [NUM_CH-1:0] pin_is_out,
    input  logic [NUM_CH-1:0] pin_disable,
    input  logic [MASK_W-1:0] mask_cycles,
    input  logic              gate_en,
    input  logic              force_fault,
    input  logic              fault_clear,
    output logic [NUM_CH-1:0] mon_bus,
    output logic              master_fault,
    output logic              stop_req
);
    logic [NUM_CH-1:0] over_mask;
    logic [NUM_CH-1:0] pin_fault;
    logic              holding;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        refcmp_lane #(.MASK_W(MASK_W)) lane_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .dut_bit     (dut_pin[g]),
            .ref_bit     (ref_pin[g]),
            .is_out      (pin_is_out[g]),
            .mask_cycles (mask_cycles),
            .over_mask   (over_mask[g])
        );
    end

    refcmp_qualify #(.NUM_CH(NUM_CH)) qual_i (
        .over_mask   (over_mask),
        .pin_disable (pin_disable),
        .gate_en     (gate_en),
        .pin_fault   (pin_fault)
    );

    refcmp_capture #(.NUM_CH(NUM_CH), .WIN_CYC(WIN_CYC)) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_fault   (pin_fault),
        .live_bus    (dut_pin),
        .fault_clear (fault_clear),
        .mon_bus     (mon_bus),
        .holding     (holding)
    );

    assign stop_req     = holding;
    assign master_fault = holding | force_fault;
endmodule

// File: rtl/refcmp_fault_det_chk.sv
module refcmp_fault_det_chk #(
    parameter int NUM_CH  = 28,
    parameter int WIN_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] dut_pin,
    input logic [NUM_CH-1:0] pin_is_out,
    input logic [NUM_CH-1:0] pin_disable,
    input logic              gate_en,
    input logic              force_fault,
    input logic              fault_clear,
    input logic [NUM_CH-1:0] mon_bus,
    input logic              master_fault,
    input logic              stop_req
);
    localparam int HW = $clog2(WIN_CYC + 2) + 1;
    localparam logic [HW-1:0] HSAT = HW'(WIN_CYC + 1);

    logic [HW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (!stop_req) begin
            hold_cnt <= '0;
        end else if (hold_cnt != HSAT) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    p_mon_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req |-> (mon_bus == dut_pin));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !fault_clear) |=> stop_req);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clear |=> !stop_req);

    p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        force_fault |-> master_fault);

    p_master_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        master_fault |-> (force_fault || stop_req));

    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> $past(gate_en));

    p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> ((mon_bus & $past(pin_disable)) == '0));

    p_inputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_req) |-> ((mon_bus & ~$past(pin_is_out)) == '0));

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && $past(stop_req) && (hold_cnt > HW'(WIN_CYC))) |-> $stable(mon_bus));
endmodule

bind refcmp_fault_det refcmp_fault_det_chk #(.NUM_CH(NUM_CH), .WIN_CYC(WIN_CYC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dut_pin      (dut_pin),
    .pin_is_out   (pin_is_out),
    .pin_disable  (pin_disable),
    .gate_en      (gate_en),
    .force_fault  (force_fault),
    .fault_clear  (fault_clear),
    .mon_bus      (mon_bus),
    .master_fault (master_fault),
    .stop_req     (stop_req)
);

// File: tb/refcmp_fault_det_tb_top.sv
module refcmp_fault_det_tb_top;
    localparam int N  = 28;
    localparam int MW = 4;
    localparam int WC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dut_pin = '0;
    logic [N-1:0]  ref_pin = '0;
    logic [N-1:0]  pin_is_out = '1;
    logic [N-1:0]  pin_disable = '0;
    logic [MW-1:0] mask_cycles = MW'(3);
    logic          gate_en = 1'b1;
    logic          force_fault = 1'b0;
    logic          fault_clear = 1'b0;
    logic [N-1:0]  mon_bus;
    logic          master_fault;
    logic          stop_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct {
        logic [N-1:0] mon;
        logic         mf;
        logic         stop;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    refcmp_fault_det #(.NUM_CH(N), .MASK_W(MW), .WIN_CYC(WC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dut_pin      (dut_pin),
        .ref_pin      (ref_pin),
        .pin_is_out   (pin_is_out),
        .pin_disable  (pin_disable),
        .mask_cycles  (mask_cycles),
        .gate_en      (gate_en),
        .force_fault  (force_fault),
        .fault_clear  (fault_clear),
        .mon_bus      (mon_bus),
        .master_fault (master_fault),
        .stop_req     (stop_req)
    );

    function automatic logic [N-1:0] bit_of(input int i);
        return N'(1) << i;
    endfunction

    task automatic check(input bit ok, input string what, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // driver: applies one cycle of stimulus at a falling edge and queues the
    // outputs expected after the following rising edge
    task automatic step(input logic [N-1:0] d, input logic [N-1:0] r, input logic clr,
                        input logic [N-1:0] emon, input logic emf, input logic estop,
                        input string tag);
        exp_t e;
        dut_pin     = d;
        ref_pin     = r;
        fault_clear = clr;
        e.mon  = emon;
        e.mf   = emf;
        e.stop = estop;
        e.tag  = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: pops one expectation per rising edge, compares mid-cycle
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(mon_bus == e.mon, "mon_bus", e.tag, mon_bus, e.mon);
            check(master_fault == e.mf, "master_fault", e.tag, N'(master_fault), N'(e.mf));
            check(stop_req == e.stop, "stop_req", e.tag, N'(stop_req), N'(e.stop));
        end
    end

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] s5, s59, s5912;
        s5    = bit_of(5);
        s59   = bit_of(5) | bit_of(9);
        s5912 = s59 | bit_of(12);
        @(negedge clk);

        // R1: reset state, live monitor
        step(bit_of(1), '0, 1'b0, bit_of(1), 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        step('0, '0, 1'b0, '0, 1'b0, 1'b0, "R1 after reset");

        // R2: input-direction pin never faults
        pin_is_out = ~bit_of(4);
        for (int k = 0; k < 6; k++)
            step(bit_of(4), '0, 1'b0, bit_of(4), 1'b0, 1'b0, "R2 input pin");
        step('0, '0, 1'b0, '0, 1'b0, 1'b0, "R2 idle");
        pin_is_out = '1;

        // R3/R7/R8/R9: mask 3, window 2
        step(s5,    '0, 1'b0, s5,    1'b0, 1'b0, "R3 len1");
        step(s59,   '0, 1'b0, s59,   1'b0, 1'b0, "R3 len2");
        step(s59,   '0, 1'b0, s59,   1'b0, 1'b0, "R3 len3");
        step(s5912, '0, 1'b0, s5,    1'b1, 1'b1, "R3 qualify R8 captured");
        step(s5912, '0, 1'b0, s59,   1'b1, 1'b1, "R7 window adds");
        step(s5912, '0, 1'b0, s59,   1'b1, 1'b1, "R7 window last");
        step(s5912, '0, 1'b0, s59,   1'b1, 1'b1, "R7 frozen R9 hold");
        step('0,    '0, 1'b1, '0,    1'b0, 1'b0, "R9 clear");

        // R4: transition restarts timing
        step(bit_of(3), '0, 1'b0, bit_of(3), 1'b0, 1'b0, "R4 a1");
        step(bit_of(3), '0, 1'b0, bit_of(3), 1'b0, 1'b0, "R4 a2");
        step(bit_of(3), '0, 1'b0, bit_of(3), 1'b0, 1'b0, "R4 a3");
        step('0, bit_of(3), 1'b0, '0, 1'b0, 1'b0, "R4 restart 1");
        step('0, bit_of(3), 1'b0, '0, 1'b0, 1'b0, "R4 restart 2");
        step('0, bit_of(3), 1'b0, '0, 1'b0, 1'b0, "R4 restart 3");
        step('0, bit_of(3), 1'b0, bit_of(3), 1'b1, 1'b1, "R4 restart 4 qualifies");
        step('0, '0, 1'b1, '0, 1'b0, 1'b0, "R4 clear");

        // R3 boundary: exactly mask cycles of mismatch does not qualify
        for (int k = 0; k < 3; k++)
            step(bit_of(15), '0, 1'b0, bit_of(15), 1'b0, 1'b0, "R3 exact mask");
        step('0, '0, 1'b0, '0, 1'b0, 1'b0, "R3 exact mask gone");

        // R5: disabled pin
        pin_disable = bit_of(7);
        for (int k = 0; k < 6; k++)
            step(bit_of(7), '0, 1'b0, bit_of(7), 1'b0, 1'b0, "R5 disabled");
        pin_disable = '0;
        step('0, '0, 1'b0, '0, 1'b0, 1'b0, "R5 idle");

        // R6: gate low suppresses, release qualifies at once
        gate_en = 1'b0;
        for (int k = 0; k < 6; k++)
            step(bit_of(2), '0, 1'b0, bit_of(2), 1'b0, 1'b0, "R6 gate low");
        gate_en = 1'b1;
        step(bit_of(2), '0, 1'b0, bit_of(2), 1'b1, 1'b1, "R6 gate release");
        step('0, '0, 1'b1, '0, 1'b0, 1'b0, "R6 clear");

        // R10: force fault
        force_fault = 1'b1;
        step(bit_of(6), '0, 1'b0, bit_of(6), 1'b1, 1'b0, "R10 forced");
        force_fault = 1'b0;
        step('0, '0, 1'b0, '0, 1'b0, 1'b0, "R10 released");

        // R3 mask 0 qualifies on first edge
        mask_cycles = '0;
        step(bit_of(20), '0, 1'b0, bit_of(20), 1'b1, 1'b1, "R3 mask zero");
        // R9 clear wins over a still-present fault
        step(bit_of(20), '0, 1'b1, bit_of(20), 1'b0, 1'b0, "R9 clear priority");
        step('0, '0, 1'b0, '0, 1'b0, 1'b0, "R9 idle");

        // R1: reset discards a captured fault
        step(bit_of(11), '0, 1'b0, bit_of(11), 1'b1, 1'b1, "R1 capture before reset");
        rst_n = 1'b0;
        step('0, '0, 1'b0, '0, 1'b0, 1'b0, "R1 reset clears");
        rst_n = 1'b1;
        mask_cycles = MW'(3);
        step('0, '0, 1'b0, '0, 1'b0, 1'b0, "R1 idle after reset");

        @(posedge clk);
        #6;
        if (exp_q.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule